// File: doc/BRIEF.md
# Read-Once Secret Word Store

This block holds a 256-bit device secret and hands it to privileged firmware as eight 32-bit words. The words sit at eight consecutive bus addresses. A read is serviced only while the firmware-mode input is low. Each word gives its true value on the first read after reset. Every later read of that word returns zero until the next reset, so a compromised later stage cannot recover the secret by re-reading it.

Each output bit comes from its own 16-entry lookup table. Entries 0 to 7 hold that bit of words 0 to 7, and entries 8 to 15 are zero. The table address is the 3-bit word index, with that word's sticky read flag as the most significant bit. Once a flag is set, every access to that word is steered into the zero half of the table.

The secret is supplied through a parameter. The bus handshake never stalls: a ready pulse answers every chip-select cycle one clock later.

Top module: `rosecret_top`

## Requirements
- R1: While `rstN` is low at a clock edge, `rdData` becomes zero and `ready` becomes zero after that edge.
- R2: A valid read returns the stored word on `rdData` one cycle after the access if that word has not been read since reset. A valid read has `cs`=1, `we`=0, `fwMode`=0 and an address from `BASE_ADDR` to `BASE_ADDR`+7. Word k is bits [32k+31:32k] of `SECRET`, at address `BASE_ADDR`+k.
- R3: Once a word has been read, every later valid read of it returns zero until reset.
- R4: Words may be read in any order. Reading one word does not change what any other word returns.
- R5: An access made while `fwMode`=1 returns zero and does not use up the word's single read.
- R6: If `cs` is held high on one word address over several cycles, the first response carries the word and every following response is zero.
- R7: An access to an address outside the eight-word window returns zero and does not use up any word's read.
- R8: A write access (`we`=1) returns zero and does not use up the addressed word's read.
- R9: `ready` is 1 exactly one cycle after each cycle in which `cs` is 1, for valid and ignored accesses alike, and 0 otherwise.
- R10: Reset clears all read flags but leaves the secret intact, so after reset every word can be read once more with its true value.
- R11: `rdData` is zero one cycle after any cycle in which `cs` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| fwMode | input | 1 | High while non-firmware code runs; blocks secret access |
| cs | input | 1 | Chip select |
| we | input | 1 | Write enable (writes are ignored) |
| addr | input | 8 | Word address |
| rdData | output | 32 | Registered read data |
| ready | output | 1 | One-cycle acknowledge for each chip-select cycle |

## Verification
Every result here appears exactly one clock edge after the bus cycle that caused it. This holds for `rdData`, for `ready`, and for the read flag that decides what the next access returns. The bench therefore drives each bus cycle on a falling edge and lets one rising edge capture it. It checks both outputs on the following falling edge, before the next stimulus can reach them. Flag effects, including the absence of a flag change after a blocked or ignored access, are confirmed through a later valid read of the same word, checked at its own one-cycle slot.

// File: rtl/rosecret_pkg.sv
package rosecret_pkg;

  localparam int DATA_W    = 32;
  localparam int WORDS     = 8;
  localparam int IDX_W     = $clog2(WORDS);
  localparam int LUT_DEPTH = 2 * WORDS;
  localparam int LUT_AW    = IDX_W + 1;
  localparam int SECRET_W  = DATA_W * WORDS;
  localparam int ADDR_W    = 8;

  // Strobes sent from control to datapath for one bus cycle
  typedef struct packed {
    logic             readEn;   // valid read this cycle
    logic [IDX_W-1:0] wordIdx;  // word offset inside the window
    logic             flagSet;  // word already consumed (table MSB)
  } ctrlStrobe_t;

  // Build the contents of the lookup table for one output bit:
  // lower half holds the secret bit of each word, upper half is zero.
  function automatic logic [LUT_DEPTH-1:0] lutImage(
    input logic [SECRET_W-1:0] secret,
    input int                  bitPos
  );
    logic [LUT_DEPTH-1:0] img;
    img = '0;
    for (int j = 0; j < WORDS; j++) begin
      img[j] = secret[j*DATA_W + bitPos];
    end
    return img;
  endfunction

endpackage

// File: rtl/rosecret_ctrl.sv
module rosecret_ctrl
  import rosecret_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fwMode,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobe_t       strobe,
  output logic              readyQ
);

  logic [ADDR_W-1:0] offset;
  logic              inWindow;
  logic              accessValid;
  logic [IDX_W-1:0]  wordIdx;
  logic [WORDS-1:0]  readFlags;

  // Address decode: offset from base, window test on the full offset
  always_comb begin
    offset      = addr - BASE_ADDR;
    inWindow    = (offset < ADDR_W'(WORDS));
    wordIdx     = offset[IDX_W-1:0];
    accessValid = cs && !we && !fwMode && inWindow;
  end

  always_comb begin
    strobe.readEn  = accessValid;
    strobe.wordIdx = wordIdx;
    strobe.flagSet = readFlags[wordIdx];
  end

  // Sticky per-word consumed flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readFlags <= '0;
    end else if (accessValid) begin
      readFlags[wordIdx] <= 1'b1;
    end
  end

  // Zero-wait acknowledge for every chip-select cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= 1'b0;
    end else begin
      readyQ <= cs;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((readFlags | $past(readFlags)) == readFlags)); // R3

  AST_FLAG_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(accessValid)) |-> $stable(readFlags)); // R8

  AST_FLAG_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($countones(readFlags) <= $countones($past(readFlags)) + 1)); // R4

endmodule

// File: rtl/rosecret_data.sv
module rosecret_data
  import rosecret_pkg::*;
#(
  parameter logic [SECRET_W-1:0] SECRET = {WORDS{32'h0}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] rdData
);

  logic [LUT_AW-1:0] lutAddr;
  logic [DATA_W-1:0] lutOut;
  logic [DATA_W-1:0] rdQ;

  // Consumed flag forms the top address bit, steering to the zero half
  assign lutAddr = {strobe.flagSet, strobe.wordIdx};

  for (genvar n = 0; n < DATA_W; n++) begin : g_bitLut
    localparam logic [LUT_DEPTH-1:0] IMG = lutImage(SECRET, n);
    assign lutOut[n] = IMG[lutAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (strobe.readEn) begin
      rdQ <= lutOut;
    end else begin
      rdQ <= '0;
    end
  end

  assign rdData = rdQ;

  AST_REREAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobe.readEn) && $past(strobe.flagSet)) |-> (rdData == '0)); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strobe.readEn)) |-> (rdData == '0)); // R11

endmodule

// File: rtl/rosecret_top.sv
module rosecret_top
  import rosecret_pkg::*;
#(
  parameter logic [ADDR_W-1:0]   BASE_ADDR = 8'h40,
  parameter logic [SECRET_W-1:0] SECRET    = {
    32'h7E15_9A02, 32'h3C48_D1F6, 32'hB2E7_0459, 32'h16AF_C38D,
    32'hD90B_5E74, 32'h48C6_2FA1, 32'hA3F1_7B0C, 32'h5D29_E6B8}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fwMode,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdData,
  output logic              ready
);

  ctrlStrobe_t strobe;

  rosecret_ctrl #(
    .BASE_ADDR (BASE_ADDR)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .fwMode (fwMode),
    .cs     (cs),
    .we     (we),
    .addr   (addr),
    .strobe (strobe),
    .readyQ (ready)
  );

  rosecret_data #(
    .SECRET (SECRET)
  ) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdData (rdData)
  );

  AST_FW_BLOCKS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(fwMode)) |-> (rdData == '0)); // R5

  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(we)) |-> (rdData == '0)); // R8

  AST_READY_FOLLOWS_CS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (ready == $past(cs))); // R9

  AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cs) && ((($past(addr) - BASE_ADDR) & 8'hF8) != 8'h00))
      |-> (rdData == '0)); // R7

endmodule

// File: tb/rosecret_top_bench.sv
module rosecret_top_bench;
  import rosecret_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] BASE = 8'h40;

  function automatic logic [31:0] benchWord(input int k);
    return 32'h9E37_79B9 * (k + 3) ^ (32'h0101_0101 << k);
  endfunction

  function automatic logic [255:0] benchSecret();
    logic [255:0] s;
    for (int k = 0; k < 8; k++) s[k*32 +: 32] = benchWord(k);
    return s;
  endfunction

  localparam logic [255:0] SECRET = benchSecret();

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fwMode = 1'b0;
  logic        cs = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] rdData;
  logic        ready;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rosecret_top #(.BASE_ADDR(BASE), .SECRET(SECRET)) u_rosecret_top (
    .clk(clk), .rstN(rstN), .fwMode(fwMode), .cs(cs), .we(we),
    .addr(addr), .rdData(rdData), .ready(ready)
  );

  // expSel: 0..7 = that word, 8 = zero
  typedef struct packed {
    logic       vCs;
    logic       vWe;
    logic       vFw;
    logic [7:0] vAddr;
    logic [3:0] expSel;
    logic       expReady;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 1'b0, 8'h43, 4'd3, 1'b1},  // R2 first read word3
    '{1'b1, 1'b0, 1'b0, 8'h43, 4'd8, 1'b1},  // R3 reread zero
    '{1'b1, 1'b0, 1'b1, 8'h40, 4'd8, 1'b1},  // R5 firmware mode high
    '{1'b1, 1'b1, 1'b0, 8'h40, 4'd8, 1'b1},  // R8 write ignored
    '{1'b1, 1'b0, 1'b0, 8'h48, 4'd8, 1'b1},  // R7 above window
    '{1'b1, 1'b0, 1'b0, 8'h3F, 4'd8, 1'b1},  // R7 below window
    '{1'b0, 1'b0, 1'b0, 8'h41, 4'd8, 1'b0},  // R11 idle, R9 no ready
    '{1'b1, 1'b0, 1'b0, 8'h40, 4'd0, 1'b1},  // R5 R8 word0 still fresh
    '{1'b1, 1'b0, 1'b0, 8'h47, 4'd7, 1'b1},  // R4 out of order, R7 edge
    '{1'b1, 1'b0, 1'b0, 8'h41, 4'd1, 1'b1},  // R4
    '{1'b1, 1'b0, 1'b0, 8'h40, 4'd8, 1'b1},  // R3 word0 consumed
    '{1'b1, 1'b0, 1'b0, 8'h42, 4'd2, 1'b1},  // R2
    '{1'b1, 1'b0, 1'b0, 8'h44, 4'd4, 1'b1},  // R2
    '{1'b1, 1'b0, 1'b0, 8'h46, 4'd6, 1'b1}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busCycle(input logic c, input logic w, input logic f, input logic [7:0] a);
    @(negedge clk);
    cs = c; we = w; fwMode = f; addr = a;
    @(posedge clk);
    @(negedge clk);
    cs = 1'b0; we = 1'b0; fwMode = 1'b0;
  endtask

  function automatic logic [31:0] expOf(input logic [3:0] sel);
    return (sel < 4'd8) ? benchWord(int'(sel)) : 32'h0;
  endfunction

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rdData", rdData, 32'h0);
    check("R1 ready", {31'h0, ready}, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      busCycle(VECS[i].vCs, VECS[i].vWe, VECS[i].vFw, VECS[i].vAddr);
      check($sformatf("vec%0d R2-table data", i), rdData, expOf(VECS[i].expSel));
      check($sformatf("vec%0d R9 ready", i), {31'h0, ready}, {31'h0, VECS[i].expReady});
    end

    // R6: hold cs high on word5 for three cycles
    @(negedge clk);
    cs = 1'b1; we = 1'b0; fwMode = 1'b0; addr = BASE + 8'd5;
    @(posedge clk); @(negedge clk);
    check("R6 first", rdData, benchWord(5));
    @(posedge clk); @(negedge clk);
    check("R6 second", rdData, 32'h0);
    check("R9 held ready", {31'h0, ready}, 32'h1);
    @(posedge clk); @(negedge clk);
    check("R6 third", rdData, 32'h0);
    cs = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R11 after release", rdData, 32'h0);
    check("R9 after release", {31'h0, ready}, 32'h0);

    // R1 during reset with cs asserted
    rstN = 1'b0; cs = 1'b1; addr = BASE;
    @(posedge clk); @(negedge clk);
    check("R1 reset data", rdData, 32'h0);
    check("R1 reset ready", {31'h0, ready}, 32'h0);
    cs = 1'b0;
    @(posedge clk); @(negedge clk);
    rstN = 1'b1;

    // R10: flags cleared, secret intact
    busCycle(1'b1, 1'b0, 1'b0, BASE + 8'd3);
    check("R10 word3 again", rdData, benchWord(3));
    busCycle(1'b1, 1'b0, 1'b0, BASE + 8'd5);
    check("R10 word5 again", rdData, benchWord(5));
    busCycle(1'b1, 1'b0, 1'b0, BASE + 8'd3);
    check("R10 R3 word3 consumed", rdData, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule